// File: doc/BRIEF.md
# Stack Machine Decode and Execute Core

This block forms the back half of a four-stage stack-machine pipeline. The stages are translate, microinstruction fetch, decode, and execute. The block receives one microinstruction per cycle from the fetch stage. In decode it classifies each instruction by its effect on stack depth and computes the stack-memory address for the spill or fill the instruction needs. In execute it updates the two top-of-stack registers. Every instruction completes in one cycle unless it is waiting on the memory port.

Only the top two stack entries live in registers, `tos` and `nos`. Deeper entries live in a small stack RAM with a one-cycle read. A push writes the old `nos` into the RAM slot just above the stack pointer. A pop refills `nos` from the slot at the stack pointer. The read for a fill is issued in decode, so the data is ready when the instruction reaches execute. A pop that directly follows a push picks up the spilled value from a bypass register instead of the RAM, so the pair causes no stall.

Loads and stores use a request/ready memory port. The whole pipeline freezes until ready is high. A branch-if-zero is resolved in execute. When taken, it signals a redirect to the fetch stage and discards the one instruction held in decode.

Top module: `smc_core`

## Requirements
- R1: After synchronous reset, `tos_o`, `nos_o` and `sp_o` are zero, `mem_req` and `redirect_valid` are low, and `in_ready` is high.
- R2: The opcode is `in_inst[31:28]`. Opcode 4 (ALU) combines NOS as the left operand with TOS as the right operand, chosen by `in_inst[2:0]`: 0 add, 1 NOS-TOS, 2 and, 3 or, 4 xor, 5 NOS shifted left by TOS[4:0], 6 NOS shifted right arithmetically by TOS[4:0], 7 pass NOS. The result becomes TOS, the stack pops, and SP falls by one.
- R3: Opcode 1 (LIT) pushes the sign-extended `in_inst[15:0]`. Opcode 2 (DUP) pushes a copy of TOS. A push moves the old TOS into NOS, spills the old NOS to the stack RAM, and raises SP by one.
- R4: A pop moves NOS into TOS and refills NOS with the most recently spilled value that has not yet been refilled, so values return in last-in, first-out order through at least 12 spilled levels. Opcode 3 (DROP) is a plain pop.
- R5: A sequence that alternates pushes and pops back to back, with no memory or branch instructions, never drops `in_ready` and yields correct results.
- R6: Opcode 8 (SWAP) exchanges TOS and NOS. Opcode 0 and opcodes 9 to 15 change no state. Neither changes SP.
- R7: Opcode 5 (LOAD) replaces TOS with the data read at the address held in TOS. SP is unchanged.
- R8: Opcode 6 (STORE) writes NOS to the address held in TOS, then pops, which leaves the stored value in TOS.
- R9: While a load or store is in execute and `mem_ready` is low, `in_ready` is low and TOS and SP hold. The number of stall cycles equals the number of wait cycles.
- R10: Opcode 7 (BZ) pops TOS. If the popped value was zero, `redirect_valid` pulses for exactly one cycle with `redirect_pc` equal to `in_inst[7:0]`. The instruction held in decode is discarded and leaves the stack untouched.
- R11: If BZ pops a nonzero value, no redirect occurs and the following instructions run in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A microinstruction is offered |
| in_inst | input | IW | Microinstruction word |
| in_ready | output | 1 | Offered word is taken at this edge |
| redirect_valid | output | 1 | Taken branch; fetch must restart at `redirect_pc` |
| redirect_pc | output | UAW | Branch target microcode address |
| mem_req | output | 1 | Load or store in progress |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | DW | Memory address (TOS) |
| mem_wdata | output | DW | Store data (NOS) |
| mem_rdata | input | DW | Load data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| tos_o | output | DW | Top-of-stack register |
| nos_o | output | DW | Next-of-stack register |
| sp_o | output | SAW | Stack pointer into the stack RAM |

## Verification
The bench sweeps every ALU function over an 8-by-8 grid of signed operands. A wrong operand order or a logical instead of arithmetic shift would leave a wrong TOS. Push-then-pop pairs and a 12-deep fill and drain test the spill bypass: a design that read the stack RAM in the same cycle as the spill would return stale data, and the bench would see a wrong sum. Loads and stores run at zero to three wait cycles. A design that let intake or TOS move while not ready would show extra or missing stall cycles or a wrong value. Taken, untaken and looping branches detect a wrong-path instruction that leaks through the flush, because the leaked value would change TOS, NOS or SP.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LIT   = 4'd1,
    OP_DUP   = 4'd2,
    OP_DROP  = 4'd3,
    OP_ALU   = 4'd4,
    OP_LOAD  = 4'd5,
    OP_STORE = 4'd6,
    OP_BZ    = 4'd7,
    OP_SWAP  = 4'd8
  } op_e;

  // stack-depth effect of an instruction
  typedef enum logic [1:0] {
    SC_HOLD = 2'd0,
    SC_PUSH = 2'd1,
    SC_POP  = 2'd2
  } sclass_e;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_SHL  = 3'd5,
    FN_SRA  = 3'd6,
    FN_PASS = 3'd7
  } alu_e;

  // source of the next top-of-stack value
  typedef enum logic [2:0] {
    TS_KEEP = 3'd0,
    TS_IMM  = 3'd1,
    TS_NOS  = 3'd2,
    TS_ALU  = 3'd3,
    TS_MEM  = 3'd4
  } tsel_e;

  // source of the next next-of-stack value
  typedef enum logic [1:0] {
    NS_KEEP = 2'd0,
    NS_TOS  = 2'd1,
    NS_FILL = 2'd2
  } nsel_e;

  typedef struct packed {
    sclass_e cls;
    tsel_e   tsel;
    nsel_e   nsel;
    alu_e    fn;
    logic    is_load;
    logic    is_store;
    logic    is_bz;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{cls: SC_HOLD, tsel: TS_KEEP, nsel: NS_KEEP,
                                fn: FN_ADD, is_load: 1'b0, is_store: 1'b0,
                                is_bz: 1'b0};

endpackage

// File: rtl/smc_alu.sv
module smc_alu
  import smc_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_e          fn,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res
);
  localparam int SHW = $clog2(DW);

  logic [SHW-1:0] shamt;
  assign shamt = rhs[SHW-1:0];

  logic unused_rhs_hi;
  assign unused_rhs_hi = ^rhs[DW-1:SHW];

  always_comb begin
    case (fn)
      FN_ADD:  res = lhs + rhs;
      FN_SUB:  res = lhs - rhs;
      FN_AND:  res = lhs & rhs;
      FN_OR:   res = lhs | rhs;
      FN_XOR:  res = lhs ^ rhs;
      FN_SHL:  res = lhs << shamt;
      FN_SRA:  res = $unsigned($signed(lhs) >>> shamt);
      default: res = lhs;
    endcase
  end
endmodule

// File: rtl/smc_stack_ram.sv
module smc_stack_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  // write port: spills from the execute stage
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // read port: fills issued from decode, held while the pipe is frozen
  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/smc_decode.sv
module smc_decode
  import smc_pkg::*;
#(
  parameter int IW  = 32,
  parameter int DW  = 32,
  parameter int UAW = 8,
  parameter int SAW = 4
) (
  input  logic [IW-1:0]  inst,
  input  logic [SAW-1:0] sp,
  output ctl_t           ctl,
  output logic [DW-1:0]  imm,
  output logic [UAW-1:0] target,
  output logic [SAW-1:0] fill_addr,
  output logic [SAW-1:0] spill_addr,
  output logic [SAW-1:0] sp_next
);
  localparam int IMMW  = 16;
  localparam int OPLSB = IW - 4;

  logic [3:0] opc;
  assign opc = inst[IW-1:OPLSB];

  logic unused_mid;
  assign unused_mid = ^inst[OPLSB-1:IMMW];

  assign imm    = {{(DW-IMMW){inst[IMMW-1]}}, inst[IMMW-1:0]};
  assign target = inst[UAW-1:0];

  always_comb begin
    ctl    = CTL_IDLE;
    ctl.fn = alu_e'(inst[2:0]);
    case (opc)
      OP_LIT:   begin ctl.cls = SC_PUSH; ctl.tsel = TS_IMM;  ctl.nsel = NS_TOS;  end
      OP_DUP:   begin ctl.cls = SC_PUSH; ctl.tsel = TS_KEEP; ctl.nsel = NS_TOS;  end
      OP_DROP:  begin ctl.cls = SC_POP;  ctl.tsel = TS_NOS;  ctl.nsel = NS_FILL; end
      OP_ALU:   begin ctl.cls = SC_POP;  ctl.tsel = TS_ALU;  ctl.nsel = NS_FILL; end
      OP_LOAD:  begin ctl.tsel = TS_MEM; ctl.is_load = 1'b1; end
      OP_STORE: begin
        ctl.cls = SC_POP; ctl.tsel = TS_NOS; ctl.nsel = NS_FILL; ctl.is_store = 1'b1;
      end
      OP_BZ:    begin
        ctl.cls = SC_POP; ctl.tsel = TS_NOS; ctl.nsel = NS_FILL; ctl.is_bz = 1'b1;
      end
      OP_SWAP:  begin ctl.tsel = TS_NOS; ctl.nsel = NS_TOS; end
      default:  ctl = CTL_IDLE;
    endcase
  end

  // stack RAM addresses from the push/pop class, one stage ahead of execute
  assign fill_addr  = sp;
  assign spill_addr = sp + SAW'(1);

  always_comb begin
    case (ctl.cls)
      SC_PUSH: sp_next = sp + SAW'(1);
      SC_POP:  sp_next = sp - SAW'(1);
      default: sp_next = sp;
    endcase
  end
endmodule

// File: rtl/smc_core.sv
module smc_core
  import smc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int IW     = 32,
  parameter int UAW    = 8,
  parameter int SDEPTH = 16,
  localparam int SAW   = $clog2(SDEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [IW-1:0]  in_inst,
  output logic           in_ready,
  output logic           redirect_valid,
  output logic [UAW-1:0] redirect_pc,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ready,
  output logic [DW-1:0]  tos_o,
  output logic [DW-1:0]  nos_o,
  output logic [SAW-1:0] sp_o
);
  // ---------------- decode stage state ----------------
  logic           d_valid;
  logic [IW-1:0]  d_inst;
  logic [SAW-1:0] sp_q;

  ctl_t           d_ctl;
  logic [DW-1:0]  d_imm;
  logic [UAW-1:0] d_tgt;
  logic [SAW-1:0] d_fill_addr;
  logic [SAW-1:0] d_spill_addr;
  logic [SAW-1:0] d_sp_next;

  smc_decode #(.IW(IW), .DW(DW), .UAW(UAW), .SAW(SAW)) u_dec (
    .inst       (d_inst),
    .sp         (sp_q),
    .ctl        (d_ctl),
    .imm        (d_imm),
    .target     (d_tgt),
    .fill_addr  (d_fill_addr),
    .spill_addr (d_spill_addr),
    .sp_next    (d_sp_next)
  );

  // ---------------- execute stage state ----------------
  logic           e_valid;
  ctl_t           e_ctl;
  logic [DW-1:0]  e_imm;
  logic [UAW-1:0] e_tgt;
  logic [SAW-1:0] e_spill_addr;
  logic           e_fwd;
  logic [DW-1:0]  fwd_q;
  logic [DW-1:0]  tos_q;
  logic [DW-1:0]  nos_q;

  logic           stall;
  logic           flush;
  logic           advance;
  logic           spill_we;
  logic           d_fwd;
  logic [DW-1:0]  ram_q;
  logic [DW-1:0]  fill_data;
  logic [DW-1:0]  alu_y;
  logic [DW-1:0]  tos_d;
  logic [DW-1:0]  nos_d;

  assign stall    = e_valid & (e_ctl.is_load | e_ctl.is_store) & ~mem_ready;
  assign flush    = e_valid & e_ctl.is_bz & (tos_q == '0);
  assign advance  = ~stall;
  assign spill_we = e_valid & (e_ctl.cls == SC_PUSH);

  // a pop in decode that reads the slot the execute-stage push is writing
  assign d_fwd = d_valid & (d_ctl.cls == SC_POP) & spill_we &
                 (e_spill_addr == d_fill_addr);

  assign fill_data = e_fwd ? fwd_q : ram_q;

  smc_stack_ram #(.DW(DW), .DEPTH(SDEPTH)) u_ram (
    .clk   (clk),
    .we    (spill_we),
    .waddr (e_spill_addr),
    .wdata (nos_q),
    .re    (advance),
    .raddr (d_fill_addr),
    .rdata (ram_q)
  );

  smc_alu #(.DW(DW)) u_alu (
    .fn  (e_ctl.fn),
    .lhs (nos_q),
    .rhs (tos_q),
    .res (alu_y)
  );

  always_comb begin
    tos_d = tos_q;
    case (e_ctl.tsel)
      TS_IMM:  tos_d = e_imm;
      TS_NOS:  tos_d = nos_q;
      TS_ALU:  tos_d = alu_y;
      TS_MEM:  tos_d = mem_rdata;
      default: tos_d = tos_q;
    endcase
  end

  always_comb begin
    nos_d = nos_q;
    case (e_ctl.nsel)
      NS_TOS:  nos_d = tos_q;
      NS_FILL: nos_d = fill_data;
      default: nos_d = nos_q;
    endcase
  end

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid <= 1'b0;
      d_inst  <= '0;
      sp_q    <= '0;
    end else if (advance) begin
      d_valid <= in_valid & ~flush;
      d_inst  <= in_inst;
      if (d_valid & ~flush) sp_q <= d_sp_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_valid      <= 1'b0;
      e_ctl        <= CTL_IDLE;
      e_imm        <= '0;
      e_tgt        <= '0;
      e_spill_addr <= '0;
      e_fwd        <= 1'b0;
      fwd_q        <= '0;
    end else if (advance) begin
      e_valid      <= d_valid & ~flush;
      e_ctl        <= d_ctl;
      e_imm        <= d_imm;
      e_tgt        <= d_tgt;
      e_spill_addr <= d_spill_addr;
      e_fwd        <= d_fwd;
      fwd_q        <= nos_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tos_q <= '0;
      nos_q <= '0;
    end else if (advance && e_valid) begin
      tos_q <= tos_d;
      nos_q <= nos_d;
    end
  end

  // ---------------- outputs ----------------
  assign in_ready       = ~stall & ~flush;
  assign redirect_valid = flush;
  assign redirect_pc    = e_tgt;
  assign mem_req        = e_valid & (e_ctl.is_load | e_ctl.is_store);
  assign mem_we         = e_valid & e_ctl.is_store;
  assign mem_addr       = tos_q;
  assign mem_wdata      = nos_q;
  assign tos_o          = tos_q;
  assign nos_o          = nos_q;
  assign sp_o           = sp_q;
endmodule

// File: rtl/smc_core_chk.sv
module smc_core_chk #(
  parameter int DW     = 32,
  parameter int SDEPTH = 16,
  localparam int SAW   = $clog2(SDEPTH)
) (
  input logic           clk,
  input logic           rst,
  input logic           in_ready,
  input logic           redirect_valid,
  input logic           mem_req,
  input logic           mem_we,
  input logic           mem_ready,
  input logic [DW-1:0]  mem_rdata,
  input logic [DW-1:0]  tos_o,
  input logic [SAW-1:0] sp_o
);
  // R9: a waiting memory access freezes intake
  assert_wait_blocks_intake_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |-> !in_ready);

  // R9: a waiting memory access leaves TOS and SP untouched
  assert_wait_holds_state_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> ($stable(tos_o) && $stable(sp_o)));

  // R7: a completed load lands the returned word in TOS
  assert_load_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ready) |=> (tos_o == $past(mem_rdata)));

  // R10: a taken branch flushes exactly one slot, so the pulse is one cycle
  assert_single_redirect_R10: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);

  // R10: the discarded instruction never moves SP and nothing is taken in
  assert_flush_no_sp_R10: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> !in_ready ##1 $stable(sp_o));

  // R3, R4: SP moves by at most one entry per cycle
  assert_sp_step_R4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (sp_o == $past(sp_o) || sp_o == SAW'($past(sp_o) + 1'b1) ||
              sp_o == SAW'($past(sp_o) - 1'b1)));
endmodule

bind smc_core smc_core_chk #(.DW(DW), .SDEPTH(SDEPTH)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_ready       (in_ready),
  .redirect_valid (redirect_valid),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_ready      (mem_ready),
  .mem_rdata      (mem_rdata),
  .tos_o          (tos_o),
  .sp_o           (sp_o)
);

// File: tb/smc_core_test.sv
module smc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 32;
  localparam int UAW = 8;
  localparam int SDEPTH = 16;
  localparam int SAW = $clog2(SDEPTH);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [IW-1:0]  in_inst = '0;
  logic           in_ready;
  logic           redirect_valid;
  logic [UAW-1:0] redirect_pc;
  logic           mem_req;
  logic           mem_we;
  logic [DW-1:0]  mem_addr;
  logic [DW-1:0]  mem_wdata;
  logic [DW-1:0]  mem_rdata = '0;
  logic           mem_ready = 1'b0;
  logic [DW-1:0]  tos_o;
  logic [DW-1:0]  nos_o;
  logic [SAW-1:0] sp_o;

  smc_core #(.DW(DW), .IW(IW), .UAW(UAW), .SDEPTH(SDEPTH)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [IW-1:0] prog [0:63];
  int plen = 0;
  logic [DW-1:0] bmem [0:63];
  int n_stall, n_redir, n_badrdy, n_notready;

  function automatic logic [IW-1:0] mk(input logic [3:0] op, input int imm);
    return {op, 12'h000, imm[15:0]};
  endfunction

  function automatic logic [DW-1:0] sx(input int v);
    logic [15:0] h;
    h = v[15:0];
    return {{16{h[15]}}, h};
  endfunction

  function automatic logic [DW-1:0] alu_ref(input int f, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (f)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[4:0];
      6: return $unsigned($signed(a) >>> b[4:0]);
      default: return a;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // acts as the fetch stage and the memory; latency = wait cycles per access
  task automatic run_prog(input int lat);
    int pc = 0;
    int wcnt = 0;
    int cyc = 0;
    int drain = 0;
    n_stall = 0; n_redir = 0; n_badrdy = 0; n_notready = 0;
    while (drain < 10 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (pc < plen) begin
        in_valid = 1'b1; in_inst = prog[pc]; drain = 0;
      end else begin
        in_valid = 1'b0; in_inst = '0; drain++;
      end
      mem_ready = 1'b0;
      #1;
      if (mem_req) begin
        mem_rdata = bmem[mem_addr[5:0]];
        if (wcnt == lat) begin
          mem_ready = 1'b1; wcnt = 0;
          if (mem_we) bmem[mem_addr[5:0]] = mem_wdata;
        end else begin
          wcnt++; n_stall++;
        end
      end
      #1;
      if (mem_req && !mem_ready && in_ready) n_badrdy++;
      if (!in_ready && pc < plen) n_notready++;
      if (redirect_valid) begin
        n_redir++; pc = int'(redirect_pc);
      end else if (in_ready && pc < plen) begin
        pc++;
      end
    end
    if (cyc >= 2000) check(1'b0, "run timeout", DW'(cyc), 0);
  endtask

  initial begin
    int vals [8] = '{0, 1, -1, 7, -32768, 32767, 3, 31};
    do_reset();

    // R1: reset state
    check(tos_o == 0, "R1 tos", tos_o, 0);
    check(nos_o == 0, "R1 nos", nos_o, 0);
    check(sp_o == 0, "R1 sp", DW'(sp_o), 0);
    check(!mem_req && !redirect_valid, "R1 req/redirect", {mem_req, redirect_valid}, 0);
    check(in_ready, "R1 in_ready", DW'(in_ready), 1);

    // R2: ALU sweep over all functions and an operand grid
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          prog[0] = mk(4'd1, vals[i]);
          prog[1] = mk(4'd1, vals[j]);
          prog[2] = mk(4'd4, f);
          plen = 3;
          run_prog(0);
          check(tos_o == alu_ref(f, sx(vals[i]), sx(vals[j])), $sformatf("R2 fn%0d", f),
                tos_o, alu_ref(f, sx(vals[i]), sx(vals[j])));
          check(sp_o == 1 && nos_o == 0, "R2 pop", DW'(sp_o), 1);
          prog[0] = mk(4'd3, 0);
          plen = 1;
          run_prog(0);
        end
      end
    end

    // R3: twelve pushes spill to the stack RAM
    do_reset();
    for (int k = 0; k < 12; k++) prog[k] = mk(4'd1, k + 1);
    plen = 12;
    run_prog(0);
    check(tos_o == 12 && nos_o == 11, "R3 top pair", tos_o, 12);
    check(sp_o == 12, "R3 sp", DW'(sp_o), 12);

    // R4: eleven adds refill in LIFO order, pop right after push uses bypass
    for (int k = 0; k < 11; k++) prog[k] = mk(4'd4, 0);
    plen = 11;
    run_prog(0);
    check(tos_o == 78, "R4 sum", tos_o, 78);
    check(nos_o == 0 && sp_o == 1, "R4 bottom", nos_o, 0);

    // R4: same fill with gaps between instructions (no bypass)
    do_reset();
    for (int k = 0; k < 6; k++) begin
      prog[2*k] = mk(4'd1, 100 * (k + 1));
      prog[2*k+1] = mk(4'd0, 0);
    end
    prog[12] = mk(4'd3, 0); prog[13] = mk(4'd0, 0);
    prog[14] = mk(4'd3, 0); prog[15] = mk(4'd0, 0);
    plen = 16;
    run_prog(0);
    check(tos_o == 400 && nos_o == 300, "R4 spaced fill", tos_o, 400);

    // R5: alternating push/pop, no intake stall
    do_reset();
    prog[0] = mk(4'd1, 10);
    for (int k = 1; k <= 10; k++) begin
      prog[2*k-1] = mk(4'd1, k);
      prog[2*k] = mk(4'd4, 0);
    end
    plen = 21;
    run_prog(0);
    check(tos_o == 65 && sp_o == 1, "R5 result", tos_o, 65);
    check(n_notready == 0, "R5 no stall", DW'(n_notready), 0);

    // R6: SWAP, DUP, NOP, undefined opcode
    do_reset();
    prog[0] = mk(4'd1, 3); prog[1] = mk(4'd1, 9); prog[2] = mk(4'd8, 0);
    plen = 3;
    run_prog(0);
    check(tos_o == 3 && nos_o == 9 && sp_o == 2, "R6 swap", tos_o, 3);
    prog[0] = mk(4'd2, 0); prog[1] = mk(4'd0, 0); prog[2] = mk(4'd12, 77);
    plen = 3;
    run_prog(0);
    check(tos_o == 3 && nos_o == 3 && sp_o == 3, "R6 dup/nop", nos_o, 3);
    prog[0] = mk(4'd4, 1);
    plen = 1;
    run_prog(0);
    check(tos_o == 0 && nos_o == 9 && sp_o == 2, "R6 after sub", nos_o, 9);

    // R7, R8, R9: store then load at several wait-state counts
    for (int lat = 0; lat < 4; lat++) begin
      for (int t = 0; t < 3; t++) begin
        int a;
        int v;
        a = 5 + 9 * t + lat;
        v = -1234 + 4321 * t + lat;
        for (int m = 0; m < 64; m++) bmem[m] = DW'(32'hA5000000 + m);
        do_reset();
        prog[0] = mk(4'd1, v); prog[1] = mk(4'd1, a); prog[2] = mk(4'd6, 0);
        plen = 3;
        run_prog(lat);
        check(bmem[a] == sx(v), "R8 stored word", bmem[a], sx(v));
        check(tos_o == sx(v) && sp_o == 1, "R8 tos after store", tos_o, sx(v));
        check(n_stall == lat, "R9 store stall cycles", DW'(n_stall), DW'(lat));
        prog[0] = mk(4'd3, 0); prog[1] = mk(4'd1, a); prog[2] = mk(4'd5, 0);
        prog[3] = mk(4'd1, a + 1); prog[4] = mk(4'd5, 0);
        plen = 5;
        run_prog(lat);
        check(tos_o == DW'(32'hA5000000 + a + 1) && nos_o == sx(v), "R7 loads",
              tos_o, DW'(32'hA5000000 + a + 1));
        check(sp_o == 2, "R7 sp", DW'(sp_o), 2);
        check(n_stall == 2 * lat, "R9 load stall cycles", DW'(n_stall), DW'(2 * lat));
        check(n_badrdy == 0, "R9 intake during wait", DW'(n_badrdy), 0);
      end
    end

    // R10: taken branch right after a push, wrong-path slot discarded
    do_reset();
    prog[0] = mk(4'd1, 4); prog[1] = mk(4'd1, 0); prog[2] = mk(4'd7, 6);
    prog[3] = mk(4'd1, 111); prog[4] = mk(4'd1, 222); prog[5] = mk(4'd1, 333);
    prog[6] = mk(4'd1, 7);
    plen = 7;
    run_prog(0);
    check(tos_o == 7 && nos_o == 4, "R10 taken stack", tos_o, 7);
    check(sp_o == 2, "R10 sp", DW'(sp_o), 2);
    check(n_redir == 1, "R10 redirect count", DW'(n_redir), 1);

    // R11: not taken
    do_reset();
    prog[1] = mk(4'd1, 5);
    run_prog(0);
    check(tos_o == 7 && nos_o == 333, "R11 fallthrough", tos_o, 7);
    check(sp_o == 5 && n_redir == 0, "R11 sp/redirect", DW'(sp_o), 5);

    // R10, R11: counting loop
    do_reset();
    prog[0] = mk(4'd1, 3); prog[1] = mk(4'd1, -1); prog[2] = mk(4'd4, 0);
    prog[3] = mk(4'd2, 0); prog[4] = mk(4'd7, 8); prog[5] = mk(4'd1, 0);
    prog[6] = mk(4'd7, 1); prog[7] = mk(4'd1, 99); prog[8] = mk(4'd1, 55);
    plen = 9;
    run_prog(0);
    check(tos_o == 55 && nos_o == 0, "R10 loop exit", tos_o, 55);
    check(sp_o == 2 && n_redir == 3, "R11 loop iterations", DW'(n_redir), 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule